// File: doc/BRIEF.md
# Predicate Next-Active-Lane Finder

This block steps through the true lanes of a scalable-vector predicate, one lane per call. It takes a select predicate (the mask), an operand predicate and a 2-bit element size code. It locates the highest true element of the operand. It then searches the mask upward from the element just above that one. The output predicate has every bit cleared except the lowest bit of the element it finds. Four condition flags are derived from that result, measured against the mask.

A loop that starts with an all-false operand visits every mask-true element in ascending order. On each pass it feeds the result back in as the next operand, and it stops when the result comes back empty. The vector length is a parameter, and the predicates carry one bit per vector byte. A request is accepted whenever `in_valid` is high, and its result appears registered one clock later.

Top module: `pred_next_lane`

## Requirements
- R1: Size code s (0 to 3) selects elements of 2^s bytes. Element e occupies predicate bits [e*2^s +: 2^s]. An element is active only when its lowest slot bit is set, and the other slot bits of both mask and operand are ignored.
- R2: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low otherwise. The result and flags belong to that request.
- R3: The search begins at the element one above the highest active operand element, or at element 0 when no operand element is active.
- R4: The result has only the lowest bit of the first mask-active element at or after the search start. If no such element exists, the result is all zeros.
- R5: `flag_n` is 1 when the result is set at the lowest mask-active element.
- R6: `flag_z` is 1 when no mask-active element of the result is set.
- R7: `flag_c` is 0 when the result is set at the highest mask-active element, and 1 otherwise.
- R8: `flag_v` is always 0.
- R9: With no mask-active element, the result is zero, with N=0, Z=1 and C=1.
- R10: While reset is asserted, `out_valid`, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| size_code | input | 2 | Element size code (R1) |
| mask_pred | input | VLEN/8 | Select predicate |
| op_pred | input | VLEN/8 | Operand predicate |
| out_valid | output | 1 | Result strobe |
| res_pred | output | VLEN/8 | One-hot result predicate |
| flag_n | output | 1 | Result set at first mask-active element |
| flag_z | output | 1 | No mask-active element set in result |
| flag_c | output | 1 | Inverse of result set at last mask-active element |
| flag_v | output | 1 | Always zero |

## Verification
The hardest case to reach is a slot whose lowest bit is clear while its higher bits are set. Such a slot must be ignored in both predicates, but random data rarely isolates it. Directed requests fill only the upper slot bits of the mask or the operand at wide element sizes. Other directed requests place the operand's last active element at the top element, so the search runs off the end. Random requests then mix all four size codes against a reference loop that walks the elements one at a time.

// File: rtl/pred_next_lane.sv
module pred_next_lane #(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      size_code,
  input  logic [VLEN/8-1:0] mask_pred,
  input  logic [VLEN/8-1:0] op_pred,
  output logic            out_valid,
  output logic [VLEN/8-1:0] res_pred,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_c,
  output logic            flag_v
);
  localparam int PL = VLEN / 8;

  logic [2:0]    span_m1;
  logic [PL-1:0] lane_start, mask_lead, op_lead;
  logic [PL-1:0] past_op, mask_last, cand, hit, mask_first;
  logic          acc_op, acc_m;

  assign span_m1 = 3'((4'd1 << size_code) - 4'd1);

  always_comb begin
    for (int i = 0; i < PL; i++)
      lane_start[i] = (3'(i) & span_m1) == 3'd0;
  end

  assign mask_lead = mask_pred & lane_start;
  assign op_lead   = op_pred & lane_start;

  always_comb begin
    acc_op = 1'b0;
    acc_m  = 1'b0;
    for (int i = PL - 1; i >= 0; i--) begin
      acc_op       = acc_op | op_lead[i];
      past_op[i]   = ~acc_op;
      mask_last[i] = mask_lead[i] & ~acc_m;
      acc_m        = acc_m | mask_lead[i];
    end
  end

  assign cand       = mask_lead & past_op;
  assign hit        = cand & (~cand + 1'b1);
  assign mask_first = mask_lead & (~mask_lead + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_pred  <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_pred <= hit;
        flag_n   <= |(hit & mask_first);
        flag_z   <= ~|(hit & mask_lead);
        flag_c   <= ~|(hit & mask_last);
      end
    end
  end

  assign flag_v = 1'b0;

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(res_pred));
  assert_in_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_pred & ~$past(mask_pred)) == '0);
  assert_n_implies_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_n) |-> (!flag_z && res_pred != '0));
  assert_empty_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_pred == '0) |=> (res_pred == '0 && flag_z && flag_c && !flag_n));
  assert_v_zero_R8: assert property (@(posedge clk) flag_v == 1'b0);
endmodule

// File: tb/pred_next_lane_tb.sv
module pred_next_lane_tb_top;
  localparam int VLEN = 256;
  localparam int PL = VLEN / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] size_code = '0;
  logic [PL-1:0] mask_pred = '0, op_pred = '0;
  logic out_valid, flag_n, flag_z, flag_c, flag_v;
  logic [PL-1:0] res_pred;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { logic [PL-1:0] res; logic n, z, c; } exp_t;
  exp_t exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  pred_next_lane #(.VLEN(VLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_code(size_code),
    .mask_pred(mask_pred), .op_pred(op_pred), .out_valid(out_valid),
    .res_pred(res_pred), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [PL-1:0] act, input logic [PL-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [1:0] s, input logic [PL-1:0] m,
                                 input logic [PL-1:0] o);
    exp_t e;
    int ps, ne, last, nxt, first_m, last_m;
    ps = 1 << s;
    ne = PL / ps;
    last = -1; first_m = -1; last_m = -1;
    for (int k = 0; k < ne; k++) begin
      if (o[k*ps]) last = k;
      if (m[k*ps]) begin
        if (first_m < 0) first_m = k;
        last_m = k;
      end
    end
    nxt = last + 1;
    while (nxt < ne && !m[nxt*ps]) nxt++;
    e.res = '0;
    if (nxt < ne) e.res[nxt*ps] = 1'b1;
    e.n = (nxt < ne) && (nxt == first_m);
    e.z = !(nxt < ne);
    e.c = !((nxt < ne) && (nxt == last_m));
    return e;
  endfunction

  task automatic drive(input logic [1:0] s, input logic [PL-1:0] m,
                       input logic [PL-1:0] o, input string tag);
    @(negedge clk);
    size_code = s; mask_pred = m; op_pred = o; in_valid = 1'b1;
    exp_q.push_back(model(s, m, o));
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(res_pred == e.res, {"R4 R3 ", t}, "result", res_pred, e.res);
          check(flag_n == e.n, {"R5 ", t}, "flag_n", PL'(flag_n), PL'(e.n));
          check(flag_z == e.z, {"R6 ", t}, "flag_z", PL'(flag_z), PL'(e.z));
          check(flag_c == e.c, {"R7 ", t}, "flag_c", PL'(flag_c), PL'(e.c));
          check(flag_v == 1'b0, "R8", "flag_v", PL'(flag_v), '0);
        end
      end else if (exp_q.size() != 0) begin
        check(1'b0, "R2", "missing out_valid", 0, 1);
        exp_q.delete();
        tag_q.delete();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && res_pred == '0 && !flag_n && !flag_z && !flag_c && !flag_v,
          "R10", "reset outputs", {out_valid, flag_n, flag_z, flag_c, flag_v}, '0);
    rst_n = 1'b1;
    idle(2);
    // R3: empty operand starts at element 0
    drive(2'd0, 32'h0000_0100, 32'h0, "R3 empty operand");
    // R3/R4: operand at top element -> none found
    drive(2'd0, 32'hFFFF_FFFF, 32'h8000_0000, "R4 past end");
    // R9: empty mask
    drive(2'd1, 32'h0, 32'h0, "R9 empty mask");
    // R1: only non-lowest slot bits in mask are ignored (words)
    drive(2'd2, 32'hEEEE_EEEE, 32'h0, "R1 mask high bits ignored");
    // R1: operand upper slot bits ignored (doublewords), search from 0
    drive(2'd3, 32'h0101_0101, 32'hFEFE_FEFE, "R1 operand high bits ignored");
    // R1: halfword stepping
    drive(2'd1, 32'h0005_0014, 32'h0000_0010, "R1 halfword step");
    // R5/R7 single active element: N=1, C=0
    drive(2'd0, 32'h0000_0400, 32'h0, "R5 R7 single");
    // back-to-back requests
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      size_code = 2'(k); mask_pred = $urandom(); op_pred = $urandom() & $urandom();
      in_valid = 1'b1;
      exp_q.push_back(model(size_code, mask_pred, op_pred));
      tag_q.push_back("R2 back-to-back");
    end
    @(negedge clk); in_valid = 1'b0;
    idle(2);
    for (int k = 0; k < 600; k++) begin
      logic [PL-1:0] m, o;
      m = $urandom();
      if (k % 3 == 0) m = m & $urandom() & $urandom();
      o = (k % 4 == 0) ? '0 : ($urandom() & $urandom() & $urandom());
      drive(2'($urandom_range(0, 3)), m, o, "random");
    end
    // full iteration loop over a mask per size
    for (int s = 0; s < 4; s++) begin
      logic [PL-1:0] cur;
      cur = '0;
      for (int k = 0; k < 40; k++) begin
        drive(2'(s), 32'hA5C3_9E17, cur, "R3 iterate");
        @(negedge clk);
        cur = res_pred;
        if (cur == '0) break;
      end
    end
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule